// File: doc/BRIEF.md
# Twelve-Bit Periodic Interval Timer

This block produces a periodic interrupt request from a slow count clock. A 12-bit up-counter in the count-clock domain starts at zero and advances once per count clock. When it reaches a programmed compare value, it wraps back to zero and raises a request that lasts one count-clock cycle. The interval between requests is therefore (compare + 1) count clocks.

Software controls the timer through a single 16-bit word on a plain register port clocked by the bus clock. The word holds a run bit at the top and the compare value in the low twelve bits.

The run bit crosses into the count domain through a synchronizer. The running state then crosses back for readback, so software sees a start or a stop only after the count domain has acted on it. The count domain keeps its own copy of the compare value and refreshes it only while the timer is stopped, so a running counter always works against one stable limit.

Top module: `ivtmr_top`

## Requirements
- R1: After reset the register reads 0x0FFF (run bit 0, compare 0xFFF) and `tick_irq` is low.
- R2: The register is written and read only as a full 16-bit word. Bit 15 is the run bit, bits 11:0 are the compare value, and bits 14:12 always read as zero, whatever was written to them.
- R3: While running with a compare value C of 1 or more, `tick_irq` is high for exactly one count-clock cycle, and successive pulses are C+1 count clocks apart.
- R4: A compare value of zero never produces an interrupt request while the timer is running.
- R5: Stopping the timer clears the counter. After a restart, the first request comes C+3 to C+5 count-clock falling edges after the write, whatever value the counter had when it was stopped.
- R6: A write that keeps the run bit at 1 while the timer is running leaves the compare value unchanged, in the readback and in the interrupt spacing.
- R7: A write changes the compare value when the stored run bit is 0, or when the write flips the run bit (0 to 1 or 1 to 0). The new value governs the next run.
- R8: Readback of bit 15 keeps its old value for at least one count-clock period after a write. Within four count clocks plus three bus clocks it shows the newly written value.
- R9: While the timer is stopped, `tick_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Control word to write |
| reg_rdata | output | 16 | Control word readback |
| cnt_clk | input | 1 | Count clock |
| cnt_rst_n | input | 1 | Asynchronous active-low reset, count domain |
| tick_irq | output | 1 | Periodic interrupt request, one count clock wide |

## Verification
The bench sweeps compare values from 1 to 12 and also checks 0xFFF, measuring the spacing and width of each pulse in count clocks. A counter that wraps one step early or late, or a pulse held for two cycles, shows up as a wrong spacing.

It stops the timer halfway through a long period and then restarts it. A counter that survives the stop would fire far too early.

It writes a new compare value while the timer runs, which a missing write guard would pass through. It writes zero as the compare value, where a naive match would fire continuously. It also samples the run bit right after each write, which catches a readback taken from the bus-side bit instead of the synchronized one.

// File: rtl/ivtmr_pkg.sv
package ivtmr_pkg;

  // Operating mode of the count-domain engine
  typedef enum logic [1:0] {
    IVT_IDLE  = 2'd0,  // stopped: counter held at zero
    IVT_HOLD  = 2'd1,  // running with zero compare: no requests
    IVT_COUNT = 2'd2   // running normally
  } ivt_mode_e;

  // A compare update is allowed while stopped or on a run-bit toggle
  function automatic logic cmp_write_ok(input logic run_now, input logic run_new);
    return (!run_now) || (run_now ^ run_new);
  endfunction

endpackage

// File: rtl/ivtmr_sync.sv
module ivtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ivtmr_ctrl_reg.sv
module ivtmr_ctrl_reg
  import ivtmr_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             run_vis_i,
  output logic             run_req_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int RUN_BIT = REG_W - 1;

  logic             run_req_q;
  logic [CMP_W-1:0] cmp_q;
  logic             wr_run;
  logic             cmp_take;   // named event: compare field accepted
  logic             unused_rsvd;

  assign wr_run      = wdata_i[RUN_BIT];
  assign cmp_take    = wr_i && cmp_write_ok(run_req_q, wr_run);
  assign unused_rsvd = ^wdata_i[RUN_BIT-1:CMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req_q <= 1'b0;
      cmp_q     <= '1;
    end else begin
      if (wr_i)     run_req_q <= wr_run;
      if (cmp_take) cmp_q     <= wdata_i[CMP_W-1:0];
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[RUN_BIT]     = run_vis_i;
    rdata_o[CMP_W-1:0]   = cmp_q;
  end

  assign run_req_o = run_req_q;
  assign cmp_o     = cmp_q;

  // R6: running and not toggling leaves compare untouched
  p_cmp_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && run_req_q && wr_run) |=> $stable(cmp_q));

  // R7: a toggling write lands its compare field
  p_cmp_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (wr_run != run_req_q)) |=> (cmp_q == $past(wdata_i[CMP_W-1:0])));

  // R8: the requested run state follows each write
  p_run_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (run_req_q == $past(wr_run)));
endmodule

// File: rtl/ivtmr_counter.sv
module ivtmr_counter
  import ivtmr_pkg::*;
#(
  parameter int CMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic             irq_o
);
  logic [CMP_W-1:0] cmp_sh;
  logic [CMP_W-1:0] cnt_q;
  logic             irq_q;
  ivt_mode_e        mode;
  logic             hit_ev;    // named event: counter reached compare

  function automatic logic [CMP_W-1:0] step_count(input logic [CMP_W-1:0] c,
                                                  input logic hit);
    return hit ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    if (!run_i)            mode = IVT_IDLE;
    else if (cmp_sh == '0) mode = IVT_HOLD;
    else                   mode = IVT_COUNT;
  end

  assign hit_ev = (mode == IVT_COUNT) && (cnt_q == cmp_sh);

  // Shadow compare refreshed only while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_sh <= '1;
    else if (!run_i) cmp_sh <= cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      case (mode)
        IVT_COUNT: cnt_q <= step_count(cnt_q, hit_ev);
        default:   cnt_q <= '0;
      endcase
      irq_q <= hit_ev;
    end
  end

  assign irq_o = irq_q;

  // R3: request is a single-cycle pulse
  p_one_cycle_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R3: counter never passes the compare value
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IVT_COUNT) |-> (cnt_q <= cmp_sh));

  // R4: zero compare stays quiet
  p_zero_cmp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IVT_HOLD) |=> !irq_q);

  // R5 and R9: stopping clears the counter and silences the output
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ((cnt_q == '0) && !irq_q));

  // R6: shadow compare frozen while running
  p_shadow_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> $stable(cmp_sh));
endmodule

// File: rtl/ivtmr_top.sv
module ivtmr_top #(
  parameter int REG_W  = 16,
  parameter int CMP_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cnt_clk,
  input  logic             cnt_rst_n,
  output logic             tick_irq
);
  logic             run_req;    // bus domain run request
  logic             run_cnt;    // run state seen by the counter
  logic             run_vis;    // run state brought back for readback
  logic [CMP_W-1:0] cmp_bus;

  ivtmr_ctrl_reg #(.REG_W(REG_W), .CMP_W(CMP_W)) u_reg (
    .clk       (bus_clk),
    .rst_n     (bus_rst_n),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .run_vis_i (run_vis),
    .run_req_o (run_req),
    .cmp_o     (cmp_bus),
    .rdata_o   (reg_rdata)
  );

  ivtmr_sync #(.STAGES(SYNC_N)) u_sync_to_cnt (
    .clk   (cnt_clk),
    .rst_n (cnt_rst_n),
    .d_i   (run_req),
    .q_o   (run_cnt)
  );

  ivtmr_sync #(.STAGES(SYNC_N)) u_sync_to_bus (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d_i   (run_cnt),
    .q_o   (run_vis)
  );

  ivtmr_counter #(.CMP_W(CMP_W)) u_cnt (
    .clk   (cnt_clk),
    .rst_n (cnt_rst_n),
    .run_i (run_cnt),
    .cmp_i (cmp_bus),
    .irq_o (tick_irq)
  );
endmodule

// File: tb/ivtmr_top_tb_top.sv
`timescale 1ns/1ps
module ivtmr_top_tb_top;
  logic        bus_clk = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        cnt_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;

  always #4  bus_clk = ~bus_clk;   // 125 MHz
  always #23 cnt_clk = ~cnt_clk;   // unrelated slow clock

  ivtmr_top dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_clk(cnt_clk),
    .cnt_rst_n(cnt_rst_n), .tick_irq(tick_irq)
  );

  function automatic logic [15:0] mk_word(input bit run, input int cmp);
    logic [15:0] w;
    w = 16'(cmp % 4096);
    w[15] = run;
    return w;
  endfunction

  function automatic int exp_gap(input int cmp);
    return cmp + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge bus_clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge bus_clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_cnt(input int n);
    repeat (n) @(negedge cnt_clk);
  endtask

  task automatic settle();
    wait_cnt(5);
    @(negedge bus_clk);
  endtask

  task automatic next_irq(input int limit, output int n);
    n = 0;
    do begin
      @(negedge cnt_clk);
      n++;
    end while (!tick_irq && n < limit);
  endtask

  // Called right after a high sample; returns spacing and width sample
  task automatic gap(input int limit, output int n, output bit wide);
    @(negedge cnt_clk);
    n = 1;
    wide = tick_irq;
    while (!tick_irq && n < limit) begin
      @(negedge cnt_clk);
      n++;
    end
  endtask

  task automatic quiet(input string req, input int n);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge cnt_clk);
      if (tick_irq) highs++;
    end
    chk(req, "requests seen in quiet window", highs, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge bus_clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual hang expected completion");
    finish_run();
  end

  initial begin
    int n;
    bit wide;
    bit early;
    #50 bus_rst_n = 1'b1;
    #50 cnt_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);

    // R1: reset value and idle output
    chk("R1", "reset readback", int'(reg_rdata), 'h0FFF);
    chk("R1", "reset irq", int'(tick_irq), 0);
    quiet("R9", 20);

    // R8: run bit readback lags the write
    bus_write(mk_word(1, 'hFFF));
    early = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (reg_rdata[15]) early = 1'b1;
      @(negedge bus_clk);
    end
    chk("R8", "run bit right after start", int'(early), 0);
    settle();
    chk("R8", "run bit after settling", int'(reg_rdata), 'h8FFF);

    // R3: maximum compare value
    next_irq(5000, n);
    chk("R3", "first pulse at 0xFFF arrived", int'(tick_irq), 1);
    gap(5000, n, wide);
    chk("R3", "pulse width at 0xFFF", int'(wide), 0);
    chk("R3", "spacing at 0xFFF", n, exp_gap('hFFF));

    bus_write(mk_word(0, 'hFFF));
    chk("R8", "run bit right after stop", int'(reg_rdata[15]), 1);
    settle();
    chk("R8", "run bit after stop settles", int'(reg_rdata[15]), 0);

    // R2: reserved bits ignored
    bus_write(16'h7ABC);
    chk("R2", "reserved bits read zero", int'(reg_rdata), 'h0ABC);
    settle();
    quiet("R9", 30);

    // R3: sweep of small compare values
    for (int c = 1; c <= 12; c++) begin
      bus_write(mk_word(0, c));
      wait_cnt(4);
      bus_write(mk_word(1, c));
      next_irq(c + 12, n);
      chk("R3", "first pulse arrived", int'(tick_irq), 1);
      for (int k = 0; k < 3; k++) begin
        gap(c + 12, n, wide);
        chk("R3", "pulse width one count clock", int'(wide), 0);
        chk("R3", "pulse spacing", n, exp_gap(c));
      end
      bus_write(mk_word(0, c));
      wait_cnt(4);
    end

    // R5: stop mid-count, restart, counter must restart from zero
    bus_write(mk_word(0, 40));
    wait_cnt(4);
    bus_write(mk_word(1, 40));
    next_irq(80, n);
    wait_cnt(20);
    bus_write(mk_word(0, 40));
    wait_cnt(6);
    bus_write(mk_word(1, 40));
    next_irq(200, n);
    chk_rng("R5", "first pulse after restart", n, 40 + 3, 40 + 5);
    bus_write(mk_word(0, 40));
    wait_cnt(4);

    // R6: compare write while running is ignored
    bus_write(mk_word(0, 5));
    wait_cnt(4);
    bus_write(mk_word(1, 5));
    next_irq(30, n);
    bus_write(mk_word(1, 9));
    settle();
    chk("R6", "compare kept while running", int'(reg_rdata), 'h8005);
    next_irq(30, n);
    for (int k = 0; k < 2; k++) begin
      gap(30, n, wide);
      chk("R6", "spacing unchanged after ignored write", n, exp_gap(5));
    end

    // R7: compare accepted on stop and on start writes
    bus_write(mk_word(0, 3));
    chk("R7", "compare taken on stop write", int'(reg_rdata[11:0]), 3);
    settle();
    bus_write(mk_word(1, 7));
    chk("R7", "compare taken on start write", int'(reg_rdata[11:0]), 7);
    next_irq(30, n);
    gap(30, n, wide);
    chk("R7", "spacing uses new compare", n, exp_gap(7));
    bus_write(mk_word(0, 7));
    settle();

    // R4: zero compare never fires
    bus_write(mk_word(0, 0));
    wait_cnt(4);
    bus_write(mk_word(1, 0));
    settle();
    chk("R4", "readback with zero compare", int'(reg_rdata), 'h8000);
    quiet("R4", 60);
    bus_write(mk_word(0, 0));
    settle();
    quiet("R9", 10);

    finish_run();
  end
endmodule